// File: doc/BRIEF.md
# Coherent Measurement Readout Bank

This block keeps the latest measurement results of a battery monitor in a byte-addressed, read-only register file. Each result is a 16-bit pair: a high byte at an even address and a low byte at the next odd address. Fifteen cell readings, one summed pack reading, three temperature readings and one signed charge-counter value are held. Measurement logic pushes new results through update strobes at any time, and the stored values change as soon as each update lands.

A host reads through a byte-wide port. A transaction opens with a start pulse that loads a read pointer. Each read request returns one byte and moves the pointer forward by one. An end pulse closes the transaction. A high-byte read captures the whole 16-bit result in a shadow register. A low-byte read of the same pair that follows it in the same transaction is served from that shadow, so the two bytes always belong to one result.

Top module: `meas_readout_bank`

## Requirements
- R1: After synchronous reset every stored result is zero and `rd_valid` is low.
- R2: Result pair k (k = 0..19) has its high byte at address 0x0C + 2k and its low byte at 0x0D + 2k. Cell i (0..14) is pair i, the pack sum is pair 15 (0x2A), temperature t (0..2) is pair 16 + t (0x2C, 0x2E, 0x30), and the charge counter is pair 19 (0x32).
- R3: For a 14-bit reading (cells and temperatures), the high byte returns data bits 13:8 in bits 5:0 with bits 7:6 zero, and the low byte returns data bits 7:0. Update bits 15:14 do not exist for these sources.
- R4: The pack sum and the charge counter are stored with all 16 bits: bits 15:8 in the high byte and bits 7:0 in the low byte.
- R5: A read request returns its byte on `rd_data` with `rd_valid` high one cycle later. `rd_valid` is low in a cycle that follows no request. A start pulse loads the pointer from `txn_addr`, and a request in the same cycle uses that address. Each request advances the pointer by one.
- R6: A low-byte read that directly follows the high-byte read of the same pair in one transaction returns the low byte of the value captured at the high-byte read, even if that pair was updated in between.
- R7: An end pulse or a new start pulse drops the captured value, so a low-byte read in a later transaction without a preceding high-byte read returns live data.
- R8: Reads of addresses below 0x0C or above 0x33 return 0x00.
- R9: A cell update with index 15 or a temperature update with index 3 changes no stored result.
- R10: An update in the same cycle as the high-byte read of that pair does not show up in that read or in the following low-byte read. Later transactions see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_upd_v | input | 1 | Cell result strobe |
| cell_upd_idx | input | 4 | Cell number 0..14 |
| cell_upd_data | input | 14 | Cell reading |
| pack_upd_v | input | 1 | Pack sum strobe |
| pack_upd_data | input | 16 | Pack sum |
| temp_upd_v | input | 1 | Temperature strobe |
| temp_upd_idx | input | 2 | Temperature channel 0..2 |
| temp_upd_data | input | 14 | Temperature reading |
| cc_upd_v | input | 1 | Charge counter strobe |
| cc_upd_data | input | 16 | Signed charge counter value |
| txn_start | input | 1 | Opens a transaction and loads the pointer |
| txn_addr | input | 8 | Start address |
| txn_end | input | 1 | Closes the transaction |
| rd_req | input | 1 | Byte read request |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |

## Verification
The overlap that matters is a result update landing on the same pair as a host read. The bench causes it in three ways: an update in the same cycle as the high-byte read, an update in an idle cycle between the two byte reads, and an update in the same cycle as the low-byte read. Both bytes are checked against a snapshot that the bench model takes before the read. A fresh transaction afterwards must show the new value, which proves that the update was delayed and not lost.

// File: rtl/readout_pkg.sv
package readout_pkg;

  typedef struct packed {
    logic       hit;
    logic       low;
    logic [7:0] slot;
  } addr_dec_t;

  function automatic addr_dec_t decode_addr(input logic [15:0] addr,
                                            input logic [15:0] base,
                                            input int          nslots);
    addr_dec_t   d;
    logic [15:0] off;
    off    = addr - base;
    d.hit  = (addr >= base) && (off < 16'(2 * nslots));
    d.low  = off[0];
    d.slot = off[8:1];
    return d;
  endfunction

endpackage

// File: rtl/readout_store.sv
module readout_store #(
  parameter int N_CELLS  = 15,
  parameter int N_TEMPS  = 3,
  parameter int NARROW_W = 14,
  parameter int WIDE_W   = 16,
  parameter int CIDX_W   = 4,
  parameter int TIDX_W   = 2,
  localparam int N_SLOTS = N_CELLS + N_TEMPS + 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cell_v,
  input  logic [CIDX_W-1:0]           cell_idx,
  input  logic [NARROW_W-1:0]         cell_data,
  input  logic                        pack_v,
  input  logic [WIDE_W-1:0]           pack_data,
  input  logic                        temp_v,
  input  logic [TIDX_W-1:0]           temp_idx,
  input  logic [NARROW_W-1:0]         temp_data,
  input  logic                        cc_v,
  input  logic [WIDE_W-1:0]           cc_data,
  output logic [N_SLOTS*WIDE_W-1:0]   slots_flat
);
  localparam int PACK_SLOT = N_CELLS;
  localparam int TEMP0     = N_CELLS + 1;
  localparam int CC_SLOT   = N_SLOTS - 1;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic              we;
    logic [WIDE_W-1:0] wd;
    logic [WIDE_W-1:0] q;

    if (s < N_CELLS) begin : g_cell
      assign we = cell_v && (cell_idx == CIDX_W'(s));
      assign wd = WIDE_W'(cell_data);
    end else if (s == PACK_SLOT) begin : g_pack
      assign we = pack_v;
      assign wd = pack_data;
    end else if (s < CC_SLOT) begin : g_temp
      assign we = temp_v && (temp_idx == TIDX_W'(s - TEMP0));
      assign wd = WIDE_W'(temp_data);
    end else begin : g_cc
      assign we = cc_v;
      assign wd = cc_data;
    end

    always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= wd;
    end

    assign slots_flat[s*WIDE_W +: WIDE_W] = q;
  end

endmodule

// File: rtl/readout_txn_ctrl.sv
module readout_txn_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [ADDR_W-1:0] ptr_q;

  // A start pulse redirects the read in the same cycle.
  assign rd_addr = txn_start ? txn_addr : ptr_q;

  always_ff @(posedge clk) begin
    if (rst)                      ptr_q <= '0;
    else if (txn_start || rd_req) ptr_q <= rd_addr + ADDR_W'(rd_req);
  end

endmodule

// File: rtl/readout_port.sv
module readout_port
  import readout_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BYTE_W    = 8,
  parameter int N_SLOTS   = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0C,
  localparam int WIDE_W   = 2 * BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_SLOTS*WIDE_W-1:0] slots_flat,
  input  logic                      txn_start,
  input  logic                      txn_end,
  input  logic                      rd_req,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [BYTE_W-1:0]         rd_data,
  output logic                      rd_valid,
  output logic                      sh_valid,
  output logic [7:0]                sh_slot,
  output logic [WIDE_W-1:0]         sh_val
);
  addr_dec_t         dec;
  logic [WIDE_W-1:0] live;
  logic              sh_hit;
  logic [BYTE_W-1:0] byte_d;
  logic              cap_hi;

  assign dec = decode_addr(16'(rd_addr), 16'(BASE_ADDR), N_SLOTS);

  always_comb begin
    live = '0;
    for (int s = 0; s < N_SLOTS; s++) begin
      if (dec.slot == 8'(s)) live = slots_flat[s*WIDE_W +: WIDE_W];
    end
  end

  // The shadow only serves the low half of the pair it was taken from,
  // and never across a start pulse.
  assign sh_hit = sh_valid && !txn_start && dec.hit && dec.low && (sh_slot == dec.slot);
  assign cap_hi = rd_req && dec.hit && !dec.low;

  always_comb begin
    if (!dec.hit)    byte_d = '0;
    else if (!dec.low) byte_d = live[WIDE_W-1 -: BYTE_W];
    else if (sh_hit) byte_d = sh_val[BYTE_W-1:0];
    else             byte_d = live[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= byte_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_valid <= 1'b0;
      sh_slot  <= '0;
      sh_val   <= '0;
    end else if (txn_end) begin
      sh_valid <= 1'b0;
    end else if (cap_hi) begin
      sh_valid <= 1'b1;
      sh_slot  <= dec.slot;
      sh_val   <= live;
    end else if (txn_start) begin
      sh_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/meas_readout_bank.sv
module meas_readout_bank #(
  parameter int N_CELLS   = 15,
  parameter int N_TEMPS   = 3,
  parameter int NARROW_W  = 14,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0C,
  localparam int WIDE_W   = 2 * BYTE_W,
  localparam int CIDX_W   = $clog2(N_CELLS),
  localparam int TIDX_W   = $clog2(N_TEMPS),
  localparam int N_SLOTS  = N_CELLS + N_TEMPS + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cell_upd_v,
  input  logic [CIDX_W-1:0]   cell_upd_idx,
  input  logic [NARROW_W-1:0] cell_upd_data,
  input  logic                pack_upd_v,
  input  logic [WIDE_W-1:0]   pack_upd_data,
  input  logic                temp_upd_v,
  input  logic [TIDX_W-1:0]   temp_upd_idx,
  input  logic [NARROW_W-1:0] temp_upd_data,
  input  logic                cc_upd_v,
  input  logic [WIDE_W-1:0]   cc_upd_data,
  input  logic                txn_start,
  input  logic [ADDR_W-1:0]   txn_addr,
  input  logic                txn_end,
  input  logic                rd_req,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                rd_valid
);
  logic [N_SLOTS*WIDE_W-1:0] slots_flat;
  logic [ADDR_W-1:0]         rd_addr_w;
  logic                      sh_valid_w;
  logic [7:0]                sh_slot_w;
  logic [WIDE_W-1:0]         sh_val_w;

  readout_store #(
    .N_CELLS (N_CELLS),
    .N_TEMPS (N_TEMPS),
    .NARROW_W(NARROW_W),
    .WIDE_W  (WIDE_W),
    .CIDX_W  (CIDX_W),
    .TIDX_W  (TIDX_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .cell_v    (cell_upd_v),
    .cell_idx  (cell_upd_idx),
    .cell_data (cell_upd_data),
    .pack_v    (pack_upd_v),
    .pack_data (pack_upd_data),
    .temp_v    (temp_upd_v),
    .temp_idx  (temp_upd_idx),
    .temp_data (temp_upd_data),
    .cc_v      (cc_upd_v),
    .cc_data   (cc_upd_data),
    .slots_flat(slots_flat)
  );

  readout_txn_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .txn_start(txn_start),
    .txn_addr (txn_addr),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr_w)
  );

  readout_port #(
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W),
    .N_SLOTS  (N_SLOTS),
    .BASE_ADDR(BASE_ADDR)
  ) u_port (
    .clk       (clk),
    .rst       (rst),
    .slots_flat(slots_flat),
    .txn_start (txn_start),
    .txn_end   (txn_end),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr_w),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .sh_valid  (sh_valid_w),
    .sh_slot   (sh_slot_w),
    .sh_val    (sh_val_w)
  );

endmodule

// File: rtl/readout_bank_chk.sv
module readout_bank_chk #(
  parameter int N_CELLS = 15,
  parameter int N_TEMPS = 3,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h0C,
  localparam int WIDE_W = 2 * BYTE_W,
  localparam int N_SLOTS = N_CELLS + N_TEMPS + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              txn_start,
  input logic              txn_end,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr_w,
  input logic [BYTE_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              sh_valid_w,
  input logic [7:0]        sh_slot_w,
  input logic [WIDE_W-1:0] sh_val_w
);
  int   off;
  logic mapped;
  logic narrow_hi;
  logic hi_rd;
  logic rst_q;

  always_comb begin
    off       = int'(rd_addr_w) - int'(BASE_ADDR);
    mapped    = (off >= 0) && (off < 2 * N_SLOTS);
    narrow_hi = mapped && (off % 2 == 0) &&
                ((off / 2 < N_CELLS) ||
                 ((off / 2 > N_CELLS) && (off / 2 <= N_CELLS + N_TEMPS)));
    hi_rd     = rd_req && mapped && (off % 2 == 0);
  end

  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      r1_reset_valid_chk: assert (!rd_valid && !sh_valid_w);
    end
  end

  // R5
  r5_req_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  // R5
  r5_idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);

  // R8
  r8_unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !mapped) |=> (rd_data == '0));

  // R3
  r3_pad_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && narrow_hi) |=> (rd_data[BYTE_W-1:BYTE_W-2] == 2'b00));

  // R7
  r7_end_drop_chk: assert property (@(posedge clk) disable iff (rst)
    txn_end |=> !sh_valid_w);

  // R6
  r6_shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_valid_w && !txn_end && !txn_start && !hi_rd) |=>
      ($stable(sh_val_w) && $stable(sh_slot_w) && sh_valid_w));

endmodule

bind meas_readout_bank readout_bank_chk #(
  .N_CELLS  (N_CELLS),
  .N_TEMPS  (N_TEMPS),
  .BYTE_W   (BYTE_W),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .txn_start (txn_start),
  .txn_end   (txn_end),
  .rd_req    (rd_req),
  .rd_addr_w (rd_addr_w),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .sh_valid_w(sh_valid_w),
  .sh_slot_w (sh_slot_w),
  .sh_val_w  (sh_val_w)
);

// File: tb/meas_readout_bank_tb.sv
module meas_readout_bank_tb;
  localparam int NS   = 20;
  localparam logic [7:0] BASE = 8'h0C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cell_upd_v = 0;
  logic [3:0]  cell_upd_idx = 0;
  logic [13:0] cell_upd_data = 0;
  logic        pack_upd_v = 0;
  logic [15:0] pack_upd_data = 0;
  logic        temp_upd_v = 0;
  logic [1:0]  temp_upd_idx = 0;
  logic [13:0] temp_upd_data = 0;
  logic        cc_upd_v = 0;
  logic [15:0] cc_upd_data = 0;
  logic        txn_start = 0;
  logic [7:0]  txn_addr = 0;
  logic        txn_end = 0;
  logic        rd_req = 0;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int n_checks = 0;
  int n_errs   = 0;
  logic [15:0] model [NS];
  logic        pend_v [NS];
  logic [15:0] pend_d [NS];

  always #2 clk = ~clk;

  meas_readout_bank u_dut (
    .clk(clk), .rst(rst),
    .cell_upd_v(cell_upd_v), .cell_upd_idx(cell_upd_idx), .cell_upd_data(cell_upd_data),
    .pack_upd_v(pack_upd_v), .pack_upd_data(pack_upd_data),
    .temp_upd_v(temp_upd_v), .temp_upd_idx(temp_upd_idx), .temp_upd_data(temp_upd_data),
    .cc_upd_v(cc_upd_v), .cc_upd_data(cc_upd_data),
    .txn_start(txn_start), .txn_addr(txn_addr), .txn_end(txn_end),
    .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic is_narrow(int slot);
    return (slot < 15) || (slot >= 16 && slot <= 18);
  endfunction

  function automatic logic [15:0] fit(int slot, logic [15:0] v);
    return is_narrow(slot) ? {2'b00, v[13:0]} : v;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  // One clock: inputs were set after a negedge, outputs seen at the next one.
  task automatic cycle();
    @(negedge clk);
    cell_upd_v = 0; pack_upd_v = 0; temp_upd_v = 0; cc_upd_v = 0;
    txn_start = 0; txn_end = 0; rd_req = 0;
    for (int s = 0; s < NS; s++) begin
      if (pend_v[s]) model[s] = pend_d[s];
      pend_v[s] = 0;
    end
  endtask

  task automatic set_upd(int slot, logic [15:0] v);
    if (slot < 15) begin
      cell_upd_v = 1; cell_upd_idx = 4'(slot); cell_upd_data = v[13:0];
    end else if (slot == 15) begin
      pack_upd_v = 1; pack_upd_data = v;
    end else if (slot < 19) begin
      temp_upd_v = 1; temp_upd_idx = 2'(slot - 16); temp_upd_data = v[13:0];
    end else begin
      cc_upd_v = 1; cc_upd_data = v;
    end
    pend_v[slot] = 1;
    pend_d[slot] = fit(slot, v);
  endtask

  task automatic upd(int slot, logic [15:0] v);
    set_upd(slot, v);
    cycle();
  endtask

  task automatic start(logic [7:0] a);
    txn_start = 1; txn_addr = a;
    cycle();
  endtask

  task automatic stop();
    txn_end = 1;
    cycle();
  endtask

  task automatic rd(output logic [7:0] d);
    rd_req = 1;
    cycle();
    d = rd_data;
  endtask

  task automatic sweep(string req);
    logic [7:0] d;
    start(BASE);
    for (int s = 0; s < NS; s++) begin
      rd(d); chk(req, d, model[s][15:8]);
      rd(d); chk(req, d, model[s][7:0]);
    end
    stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] snap, nv, oldp, oldc;
    int          slot, mode;
    void'($urandom(32'h5eed_0042));
    for (int s = 0; s < NS; s++) begin
      model[s] = 0; pend_v[s] = 0; pend_d[s] = 0;
    end

    repeat (3) @(negedge clk);
    chk("R1 rd_valid in reset", {7'b0, rd_valid}, 8'h00);
    rst = 0;
    cycle();
    // R1 and R5: every result reads zero, pointer walks the whole map
    sweep("R1");

    // R5 timing
    start(8'h2A);
    rd(d);
    chk("R5 rd_valid after request", {7'b0, rd_valid}, 8'h01);
    cycle();
    chk("R5 rd_valid after idle", {7'b0, rd_valid}, 8'h00);
    stop();

    // R2, R3, R4: known values
    upd(0, 16'h3ABC);
    upd(14, 16'hFFFF);
    upd(15, 16'hA55A);
    upd(16, 16'h1234);
    upd(17, 16'hC0DE);
    upd(18, 16'h0101);
    upd(19, 16'h8001);
    upd(7, 16'h2468);
    start(8'h0C); rd(d); chk("R3 cell0 hi", d, 8'h3A); rd(d); chk("R3 cell0 lo", d, 8'hBC); stop();
    start(8'h28); rd(d); chk("R3 cell14 hi masked", d, 8'h3F); rd(d); chk("R3 cell14 lo", d, 8'hFF); stop();
    start(8'h2A); rd(d); chk("R4 pack hi", d, 8'hA5); rd(d); chk("R4 pack lo", d, 8'h5A); stop();
    start(8'h32); rd(d); chk("R4 cc hi", d, 8'h80); rd(d); chk("R4 cc lo", d, 8'h01); stop();
    start(8'h2E); rd(d); chk("R2 temp1 hi", d, 8'h00); rd(d); chk("R2 temp1 lo", d, 8'hDE); stop();
    sweep("R2");

    // R5: start and read in the same cycle, crossing from unmapped into map
    txn_start = 1; txn_addr = 8'h0B; rd(d);
    chk("R8 addr 0x0B", d, 8'h00);
    rd(d); chk("R5 auto-increment to 0x0C", d, model[0][15:8]);
    stop();

    // R8
    start(8'h00); rd(d); chk("R8 addr 0x00", d, 8'h00); stop();
    start(8'h34); rd(d); chk("R8 addr 0x34", d, 8'h00); stop();
    start(8'hFF); rd(d); chk("R8 addr 0xFF", d, 8'h00);
    rd(d); chk("R8 wrap to 0x00", d, 8'h00); stop();

    // R9: out-of-range indices
    oldp = model[15]; oldc = model[19];
    cell_upd_v = 1; cell_upd_idx = 4'd15; cell_upd_data = 14'h1555; cycle();
    temp_upd_v = 1; temp_upd_idx = 2'd3; temp_upd_data = 14'h0777; cycle();
    start(8'h2A); rd(d); chk("R9 pack hi", d, oldp[15:8]); rd(d); chk("R9 pack lo", d, oldp[7:0]); stop();
    start(8'h32); rd(d); chk("R9 cc hi", d, oldc[15:8]); rd(d); chk("R9 cc lo", d, oldc[7:0]); stop();
    sweep("R9");

    // R7: end then lone low read gives live data
    upd(3, 16'h1111);
    start(8'h12); rd(d); chk("R7 hi", d, 8'h11); stop();
    upd(3, 16'h2222);
    start(8'h13); rd(d); chk("R7 low after end", d, 8'h22); stop();
    // R7: new start without end
    start(8'h12); rd(d); chk("R7 hi second", d, 8'h22);
    upd(3, 16'h3333);
    start(8'h13); rd(d); chk("R7 low after restart", d, 8'h33); stop();

    // R6 directed
    upd(19, 16'hBEEF);
    start(8'h32); rd(d); chk("R6 hi", d, 8'hBE);
    upd(19, 16'h1357);
    rd(d); chk("R6 low from snapshot", d, 8'hEF); stop();

    // R10 directed
    upd(15, 16'h0F0F);
    start(8'h2A);
    set_upd(15, 16'hF0F0); rd(d); chk("R10 hi old", d, 8'h0F);
    rd(d); chk("R10 lo old", d, 8'h0F); stop();
    start(8'h2A); rd(d); chk("R10 hi new", d, 8'hF0); rd(d); chk("R10 lo new", d, 8'hF0); stop();

    // Random mix of pair reads with updates racing them
    for (int i = 0; i < 300; i++) begin
      slot = $urandom_range(0, NS - 1);
      upd(slot, 16'($urandom));
      snap = model[slot];
      nv   = 16'($urandom);
      mode = $urandom_range(0, 3);
      start(BASE + 8'(2 * slot));
      if (mode == 3) set_upd(slot, nv);
      rd(d); chk("R10 random hi", d, snap[15:8]);
      if (mode == 1) upd(slot, nv);
      if (mode == 2) set_upd(slot, nv);
      rd(d); chk("R6 random lo", d, snap[7:0]);
      stop();
      if (mode != 0) begin
        start(BASE + 8'(2 * slot) + 8'd1);
        rd(d); chk("R7 random live lo", d, model[slot][7:0]);
        stop();
      end
    end
    sweep("R2 final");

    summary();
  end

endmodule